// File: doc/BRIEF.md
# Thresholded Serial Receive Controller

An asynchronous serial receiver that turns frames on a single input line into characters, stores each character with two error flags in a small FIFO, and presents the lot through a four-register read/write port that acts in a single cycle. Software chooses the bit period, the parity mode and a message-length threshold. Status and interrupt report data as available only when the FIFO holds a complete message, never part of one.

Each FIFO entry packs the character in its low bits, with a parity-error flag and a framing-error flag above it. A character that has an error is still stored, so software can throw away a whole message when any of its entries is flagged. A flush command empties the FIFO. A separate enable bit gates the interrupt line.

Top module: `uart_rx_ctrl`

## Requirements
- R1: After reset the FIFO is empty, the status, control and interrupt read 0, and the baud register reads {8'h00, DIV_RST} (16'h00D8 by default).
- R2: A frame is a low start bit, CHAR_W (6) data bits LSB first, an optional parity bit and one stop bit. The start bit must still be low half a bit period after the falling edge, so a shorter low pulse stores nothing. The payload is returned in rxdata bits [5:0].
- R3: Control bits [1:0] select parity: 0 none, 1 odd, 2 even, 3 behaves as none. In odd or even mode a mismatching parity bit sets bit 6 of the stored entry.
- R4: A low stop bit sets bit 7 of the stored entry. A character with either flag set is still written to the FIFO.
- R5: Baud register bits [7:0] give the bit period in clock cycles (values below 2 act as 2). Bits [15:8] hold the threshold N. Both read back as written.
- R6: Status bit 0 is 1 exactly while the FIFO level is at least N+1.
- R7: irq_o is status bit 0 ANDed with control bit 4 (interrupt enable).
- R8: Reading rxdata returns the oldest entry and removes exactly that one. A read of an empty FIFO returns 0 and changes nothing.
- R9: Writing control with bit 3 set empties the FIFO at that edge. Bit 3 always reads 0. A flush wins over a push or a pop in the same cycle.
- R10: The FIFO holds DEPTH (16) entries. Status bit 1 is 1 while it is full, characters that arrive while it is full are dropped, and the flag stays set until a read or a flush.
- R11: Addresses are 0 control, 1 baud, 2 status, 3 rxdata. Writes to status and rxdata have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, idles high, asynchronous to the clock |
| addr_i | input | 2 | Register address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| re_i | input | 1 | Read strobe; pops the FIFO when addr_i is 3 |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| irq_o | output | 1 | Receive interrupt |

## Verification
A bit timer or shift counter that goes wrong stores wrong payloads or false flags. This shows on the first rxdata read after one frame, about ten bit periods after the stimulus. A FIFO level that goes wrong shows in the status bits and irq_o in the cycle after the push, pop or flush that corrupted it: data-available changes at the wrong message length, or full never sets or never clears. The checker watches the level between those port-visible events. It catches a level step larger than one, a flush that does not clear, and an interrupt raised below threshold in the cycle where each happens.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_BAUD = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_RXD  = 2'd3;

  localparam logic [1:0] PAR_NONE = 2'd0;
  localparam logic [1:0] PAR_ODD  = 2'd1;
  localparam logic [1:0] PAR_EVEN = 2'd2;

  localparam int CTRL_FLUSH_BIT = 3;
  localparam int CTRL_IE_BIT    = 4;
endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic rx_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rx_o   = sync_q[SYNC_STAGES-1];
  assign fall_o = prev_q & ~sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_rx_pkg::*;
#(
  parameter int CHAR_W = 6,
  parameter int DIV_W  = 8,
  localparam int ENT_W = CHAR_W + 2,
  localparam int BIT_W = (CHAR_W > 1) ? $clog2(CHAR_W) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  input  logic             fall_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [1:0]       par_mode_i,
  output logic             push_o,
  output logic [ENT_W-1:0] entry_o
);
  rx_state_e         state_q;
  logic [DIV_W-1:0]  cnt_q;
  logic [BIT_W-1:0]  bit_q;
  logic [CHAR_W-1:0] shift_q;
  logic              pbit_q;

  logic [DIV_W-1:0] eff_div, half_div;
  logic             use_par, tick, par_err;

  assign eff_div  = (div_i < DIV_W'(2)) ? DIV_W'(2) : div_i;
  assign half_div = eff_div >> 1;
  assign use_par  = (par_mode_i == PAR_ODD) || (par_mode_i == PAR_EVEN);
  assign tick     = (cnt_q == '0);

  always_comb begin
    unique case (par_mode_i)
      PAR_ODD:  par_err = ~(^shift_q ^ pbit_q);
      PAR_EVEN: par_err = ^shift_q ^ pbit_q;
      default:  par_err = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      shift_q <= '0;
      pbit_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (fall_i) begin
          state_q <= ST_START;
          cnt_q   <= half_div - DIV_W'(1);
        end
        ST_START: begin
          if (tick) begin
            if (!rx_i) begin
              state_q <= ST_DATA;
              cnt_q   <= eff_div - DIV_W'(1);
              bit_q   <= '0;
            end else begin
              state_q <= ST_IDLE;  // glitch, not a start bit
            end
          end else cnt_q <= cnt_q - DIV_W'(1);
        end
        ST_DATA: begin
          if (tick) begin
            shift_q <= {rx_i, shift_q[CHAR_W-1:1]};
            cnt_q   <= eff_div - DIV_W'(1);
            if (bit_q == BIT_W'(CHAR_W - 1)) state_q <= use_par ? ST_PAR : ST_STOP;
            else bit_q <= bit_q + BIT_W'(1);
          end else cnt_q <= cnt_q - DIV_W'(1);
        end
        ST_PAR: begin
          if (tick) begin
            pbit_q  <= rx_i;
            cnt_q   <= eff_div - DIV_W'(1);
            state_q <= ST_STOP;
          end else cnt_q <= cnt_q - DIV_W'(1);
        end
        ST_STOP: begin
          if (tick) state_q <= ST_IDLE;
          else cnt_q <= cnt_q - DIV_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // push on the stop-bit sample; flags sit above the payload
  assign push_o  = (state_q == ST_STOP) && tick;
  assign entry_o = {~rx_i, par_err, shift_q};
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  input  logic             flush_i,
  output logic [WIDTH-1:0] head_o,
  output logic [CW-1:0]    level_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o & ~flush_i;
  assign do_pop  = pop_i & ~empty_o & ~flush_i;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o  = mem_q[rd_q];
  assign level_o = cnt_q;
endmodule

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int         DEPTH   = 16,
  parameter int         CHAR_W  = 6,
  parameter int         REG_W   = 16,
  parameter logic [7:0] DIV_RST = 8'hD8,
  localparam int ENT_W = CHAR_W + 2,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  input  logic [1:0]       addr_i,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             re_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             irq_o
);
  logic [1:0]       par_q;
  logic             ie_q;
  logic [7:0]       div_q, thr_q;
  logic             rx_s, rx_fall;
  logic             push, pop, flush;
  logic [ENT_W-1:0] entry, head;
  logic [CW-1:0]    fifo_level;
  logic             fifo_full, fifo_empty, avail;

  uart_rx_sampler #(.SYNC_STAGES(2)) u_sampler (
    .clk_i, .rst_ni, .rx_i, .rx_o(rx_s), .fall_o(rx_fall)
  );

  uart_rx_deser #(.CHAR_W(CHAR_W), .DIV_W(8)) u_deser (
    .clk_i, .rst_ni, .rx_i(rx_s), .fall_i(rx_fall), .div_i(div_q),
    .par_mode_i(par_q), .push_o(push), .entry_o(entry)
  );

  uart_rx_fifo #(.DEPTH(DEPTH), .WIDTH(ENT_W)) u_fifo (
    .clk_i, .rst_ni, .push_i(push), .data_i(entry), .pop_i(pop),
    .flush_i(flush), .head_o(head), .level_o(fifo_level),
    .full_o(fifo_full), .empty_o(fifo_empty)
  );

  logic wr_ctrl, wr_baud;
  assign wr_ctrl = we_i && (addr_i == ADDR_CTRL);
  assign wr_baud = we_i && (addr_i == ADDR_BAUD);
  assign flush   = wr_ctrl && wdata_i[CTRL_FLUSH_BIT];
  assign pop     = re_i && (addr_i == ADDR_RXD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_q <= PAR_NONE;
      ie_q  <= 1'b0;
      div_q <= DIV_RST;
      thr_q <= '0;
    end else begin
      if (wr_ctrl) begin
        par_q <= wdata_i[1:0];
        ie_q  <= wdata_i[CTRL_IE_BIT];
      end
      if (wr_baud) begin
        div_q <= wdata_i[7:0];
        thr_q <= wdata_i[15:8];
      end
    end
  end

  assign avail = 32'(fifo_level) > 32'(thr_q);
  assign irq_o = avail & ie_q;

  always_comb begin
    unique case (addr_i)
      ADDR_CTRL: rdata_o = REG_W'({ie_q, 2'b00, par_q});
      ADDR_BAUD: rdata_o = {thr_q, div_q};
      ADDR_STAT: rdata_o = REG_W'({fifo_full, avail});
      default:   rdata_o = fifo_empty ? '0 : REG_W'(head);
    endcase
  end
endmodule

// File: rtl/uart_rx_ctrl_chk.sv
module uart_rx_ctrl_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          irq_o,
  input logic          ie_q,
  input logic [7:0]    thr_q,
  input logic [CW-1:0] fifo_level,
  input logic          fifo_full,
  input logic          push,
  input logic          pop,
  input logic          flush
);
  a_r10_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(fifo_level) <= DEPTH);

  a_r10_full_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_full && !pop && !flush) |=> fifo_full);

  a_r9_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> (fifo_level == '0));

  a_r8_single_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && !push && !flush && fifo_level != '0) |=>
      (fifo_level == CW'($past(fifo_level) - CW'(1))));

  a_r4_push_stores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && !pop && !flush && !fifo_full) |=>
      (fifo_level == CW'($past(fifo_level) + CW'(1))));

  a_r7_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ie_q && 32'(fifo_level) > 32'(thr_q)));
endmodule

bind uart_rx_ctrl uart_rx_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_o(irq_o), .ie_q(ie_q),
  .thr_q(thr_q), .fifo_level(fifo_level), .fifo_full(fifo_full),
  .push(push), .pop(pop), .flush(flush)
);

// File: tb/uart_rx_ctrl_tb_top.sv
module uart_rx_ctrl_tb_top;
  localparam logic [1:0] A_CTRL = 2'd0, A_BAUD = 2'd1, A_STAT = 2'd2, A_RXD = 2'd3;
  localparam int NVEC = 8;
  // {mode[17:16], data[15:10], bad_stop[9], flip_parity[8], expected entry[7:0]}
  localparam logic [17:0] VEC [NVEC] = '{
    {2'd0, 6'h2A, 1'b0, 1'b0, 8'h2A},
    {2'd1, 6'h15, 1'b0, 1'b0, 8'h15},
    {2'd1, 6'h15, 1'b0, 1'b1, 8'h55},
    {2'd2, 6'h3F, 1'b0, 1'b0, 8'h3F},
    {2'd2, 6'h01, 1'b0, 1'b1, 8'h41},
    {2'd0, 6'h00, 1'b1, 1'b0, 8'h80},
    {2'd2, 6'h3C, 1'b1, 1'b1, 8'hFC},
    {2'd3, 6'h33, 1'b0, 1'b0, 8'h33}
  };

  logic        clk = 1'b0, rst_n = 1'b0, rx = 1'b1;
  logic [1:0]  addr = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [15:0] wdata = '0, rdata;
  logic        irq;
  int          n_chk = 0, n_fail = 0, bt = 8;
  logic        done = 1'b0;

  always #2ns clk = ~clk;

  uart_rx_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .re_i(re), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    #1ns d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic line(input logic v);
    rx = v;
    repeat (bt) @(negedge clk);
  endtask

  task automatic send(input logic [5:0] d, input logic [1:0] m, input logic flip, input logic bad_stop);
    logic p;
    line(1'b0);
    for (int i = 0; i < 6; i++) line(d[i]);
    if (m == 2'd1 || m == 2'd2) begin
      p = (m == 2'd1) ? ~^d : ^d;
      line(p ^ flip);
    end
    line(~bad_stop);
    rx = 1'b1;
    repeat (2 * bt) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(A_CTRL, v); check("R1 ctrl", v, 16'h0000);
    rd(A_BAUD, v); check("R1 baud", v, 16'h00D8);
    rd(A_STAT, v); check("R1 status", v, 16'h0000);
    check("R1 irq", {15'b0, irq}, 16'h0000);
    rd(A_RXD, v); check("R8 empty read", v, 16'h0000);
    rd(A_STAT, v); check("R8 empty read no change", v, 16'h0000);

    // R5 divisor 8, threshold 0
    wr(A_BAUD, 16'h0008);
    rd(A_BAUD, v); check("R5 baud readback", v, 16'h0008);

    // vector table: R2 R3 R4
    for (int k = 0; k < NVEC; k++) begin
      wr(A_CTRL, {14'b0, VEC[k][17:16]});
      send(VEC[k][15:10], VEC[k][17:16], VEC[k][8], VEC[k][9]);
      rd(A_STAT, v); check($sformatf("R6 avail vec %0d", k), v, 16'h0001);
      rd(A_RXD, v);  check($sformatf("R2 R3 R4 entry vec %0d", k), v, {8'h00, VEC[k][7:0]});
      rd(A_STAT, v); check($sformatf("R8 drained vec %0d", k), v, 16'h0000);
    end

    // R2 short glitch ignored
    wr(A_CTRL, 16'h0000);
    rx = 1'b0; repeat (2) @(negedge clk); rx = 1'b1;
    repeat (40) @(negedge clk);
    rd(A_STAT, v); check("R2 glitch ignored", v, 16'h0000);

    // R6 R7 threshold N=2 needs 3 entries
    wr(A_BAUD, 16'h0208);
    wr(A_CTRL, 16'h0010);
    send(6'h01, 2'd0, 1'b0, 1'b0);
    send(6'h02, 2'd0, 1'b0, 1'b0);
    rd(A_STAT, v); check("R6 two of three", v, 16'h0000);
    check("R7 irq below threshold", {15'b0, irq}, 16'h0000);
    send(6'h03, 2'd0, 1'b0, 1'b0);
    rd(A_STAT, v); check("R6 three of three", v, 16'h0001);
    check("R7 irq enabled", {15'b0, irq}, 16'h0001);
    wr(A_CTRL, 16'h0000);
    @(negedge clk); check("R7 irq disabled", {15'b0, irq}, 16'h0000);
    rd(A_CTRL, v); check("R7 ctrl readback", v, 16'h0000);

    // R11 writes to status and rxdata ignored
    wr(A_STAT, 16'hFFFF);
    wr(A_RXD, 16'hFFFF);
    rd(A_STAT, v); check("R11 status write ignored", v, 16'h0001);
    rd(A_RXD, v);  check("R8 R11 oldest first", v, 16'h0001);
    rd(A_STAT, v); check("R6 R8 one popped", v, 16'h0000);
    rd(A_RXD, v);  check("R8 second", v, 16'h0002);

    // R9 flush
    wr(A_CTRL, 16'h0018);
    rd(A_RXD, v);  check("R9 flushed", v, 16'h0000);
    rd(A_CTRL, v); check("R9 flush bit reads 0", v, 16'h0010);
    wr(A_CTRL, 16'h0000);

    // R10 overflow: 18 sent, first 16 kept
    wr(A_BAUD, 16'h0008);
    for (int i = 0; i < 18; i++) send(6'(i), 2'd0, 1'b0, 1'b0);
    rd(A_STAT, v); check("R10 full set", v, 16'h0003);
    send(6'h3F, 2'd0, 1'b0, 1'b0);
    rd(A_STAT, v); check("R10 full holds", v, 16'h0003);
    rd(A_RXD, v);  check("R10 first kept", v, 16'h0000);
    rd(A_STAT, v); check("R10 full cleared by read", v, 16'h0001);
    for (int i = 1; i < 16; i++) begin
      rd(A_RXD, v); check($sformatf("R10 order %0d", i), v, 16'(i));
    end
    rd(A_STAT, v); check("R10 drops confirmed", v, 16'h0000);

    // R5 new divisor, including even parity
    bt = 16;
    wr(A_BAUD, 16'h0010);
    wr(A_CTRL, 16'h0002);
    send(6'h2D, 2'd2, 1'b0, 1'b0);
    rd(A_RXD, v); check("R5 divisor 16", v, 16'h002D);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule